// File: doc/BRIEF.md
# Cellular Seed Flood-Fill Array

This block is a two-dimensional grid of tiny cells. Each cell holds two bits: a border bit and a visited (inside) bit. It fills the interior of a closed outline by a synchronous local wave.

The host first writes the outline into the grid, one row at a time. It then marks one or more seed cells that are known to lie inside. After a start pulse, every clock cycle is one generation. In each generation, every cell that is unvisited and not border, and has a visited neighbour to the north, south, east or west, becomes visited. The wave stops against border cells and at the grid edge.

How long a fill takes depends on the shape, so the block finds the end at run time. The fill is complete after the first generation that changes no cell. The block then raises a done flag and reports how many generations changed the grid. The result is read back one row at a time through a registered read port.

Top module: `flood_fill_grid`

## Requirements
- R1: After reset, `busy`, `done` and `gen_count` are 0 and every visited bit reads 0.
- R2: While idle, `border_we` loads `border_bits` into row `border_row` (bit c is column c; row 0 is the north edge). The same write clears every visited bit in the whole grid and clears `done`.
- R3: While idle, `seed_we` marks visited each cell of row `seed_row` whose bit in `seed_bits` is 1, and clears `done`. A seed bit that falls on a border cell is ignored, and that cell stays unvisited.
- R4: While idle, `start` raises `busy` at the next clock edge and clears `gen_count` and `done`. On each later edge while busy, every unvisited non-border cell with a visited neighbour in one of the four directions becomes visited.
- R5: The wave never enters a border cell and never moves diagonally. A region enclosed by border cells with no seed inside stays unvisited.
- R6: Cells on the grid edge treat positions outside the grid as not visited, so the fill does not wrap to the opposite side.
- R7: The first busy generation that changes no cell drops `busy` and raises `done` at the same edge. `done` then holds until the next accepted border write, seed write or start.
- R8: When done, `gen_count` equals the number of generations that changed at least one cell. This is the largest four-direction path distance from a seed to a filled cell.
- R9: While `busy` is 1, `border_we`, `seed_we` and `start` have no effect.
- R10: `rd_bits` shows the visited bits of row `rd_row` one clock after `rd_row` is presented.
- R11: Several seeds fill their separate enclosed regions at the same time, and `gen_count` is the largest of the per-region depths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| border_we | input | 1 | Write one border row, clearing all visited bits |
| border_row | input | RW | Row index for the border write |
| border_bits | input | COLS | Border bits of that row |
| seed_we | input | 1 | Mark seed cells in one row |
| seed_row | input | RW | Row index for the seed write |
| seed_bits | input | COLS | Seed bits of that row |
| start | input | 1 | Begin the fill |
| rd_row | input | RW | Row index to read |
| rd_bits | output | COLS | Registered visited bits of the row read |
| busy | output | 1 | A fill is running |
| done | output | 1 | The last fill has completed |
| gen_count | output | GW | Generations that changed the grid |

## Verification
The hardest case to reach from the ports is host traffic that arrives while the wave is still moving. The window is only as long as the fill takes, so the bench starts a fill inside a box. It then issues a seed write aimed outside the box and a border write on the very next cycles, while `busy` is known to be high. Afterwards it reads the grid to show that neither write took effect. The fill results are compared with a behavioural generation-by-generation model in the bench. That model also predicts `gen_count` for corner seeds, for a fill against a border column with no wrap, and for two boxes filled at once.

// File: rtl/ff_pkg.sv
package ff_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_BORDER = 2'd1,
    OP_SEED   = 2'd2,
    OP_START  = 2'd3
  } host_op_e;
endpackage

// File: rtl/ff_cell.sv
module ff_cell (
  input  logic clk,
  input  logic rst,
  input  logic clr_all,
  input  logic ld_border,
  input  logic border_in,
  input  logic ld_seed,
  input  logic seed_in,
  input  logic step,
  input  logic nb_n,
  input  logic nb_s,
  input  logic nb_e,
  input  logic nb_w,
  output logic visited_q,
  output logic grow
);
  logic border_q;
  logic nb_any;

  assign nb_any = nb_n | nb_s | nb_e | nb_w;
  assign grow   = step & ~visited_q & ~border_q & nb_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      border_q  <= 1'b0;
      visited_q <= 1'b0;
    end else begin
      if (ld_border) border_q <= border_in;
      if (clr_all)
        visited_q <= 1'b0;
      else if (ld_seed && seed_in && !border_q)
        visited_q <= 1'b1;
      else if (grow)
        visited_q <= 1'b1;
    end
  end

  // R5: a border cell never holds the inside mark
  assert_border_never_inside_R5: assert property (@(posedge clk) disable iff (rst)
    !(border_q && visited_q));

  // R2: the visited bit only falls when the grid is cleared by a border write
  assert_clear_only_on_border_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(visited_q) |-> $past(clr_all));

  // R4: a cell that becomes inside during a fill had an inside neighbour
  assert_grow_needs_neighbour_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(visited_q) && $past(step)) |-> $past(nb_any));
endmodule

// File: rtl/ff_ctrl.sv
module ff_ctrl #(
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_go,
  input  logic          clear_done,
  input  logic          any_grow,
  output logic          busy,
  output logic          done,
  output logic [GW-1:0] gen
);
  localparam logic [GW-1:0] GEN_MAX = {GW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      gen  <= '0;
    end else if (start_go) begin
      busy <= 1'b1;
      done <= 1'b0;
      gen  <= '0;
    end else if (busy) begin
      if (any_grow) begin
        if (gen != GEN_MAX) gen <= gen + 1'b1;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else if (clear_done) begin
      done <= 1'b0;
    end
  end

  // R7: busy and done are never high together
  assert_busy_done_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R7: done rises only after a busy generation that changed nothing
  assert_done_after_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(busy) && !$past(any_grow)));

  // R8: during a fill the count steps by at most one per generation
  assert_gen_step_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (gen == $past(gen) || gen == $past(gen) + 1'b1));
endmodule

// File: rtl/ff_rdport.sv
module ff_rdport #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROWS*COLS-1:0] vis_flat,
  input  logic [RW-1:0]        rd_row,
  output logic [COLS-1:0]      rd_bits
);
  logic [COLS-1:0] row_vec [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_rows
    assign row_vec[r] = vis_flat[r*COLS +: COLS];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_bits <= '0;
    else if (int'(rd_row) < ROWS)
      rd_bits <= row_vec[rd_row];
    else
      rd_bits <= '0;
  end
endmodule

// File: rtl/flood_fill_grid.sv
module flood_fill_grid #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int GW   = 16,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            border_we,
  input  logic [RW-1:0]   border_row,
  input  logic [COLS-1:0] border_bits,
  input  logic            seed_we,
  input  logic [RW-1:0]   seed_row,
  input  logic [COLS-1:0] seed_bits,
  input  logic            start,
  input  logic [RW-1:0]   rd_row,
  output logic [COLS-1:0] rd_bits,
  output logic            busy,
  output logic            done,
  output logic [GW-1:0]   gen_count
);
  import ff_pkg::*;

  localparam int NCELL = ROWS * COLS;

  host_op_e         op;
  logic [NCELL-1:0] vis_flat;
  logic [NCELL-1:0] grow_flat;
  logic             any_grow;

  always_comb begin
    if (busy)           op = OP_IDLE;
    else if (border_we) op = OP_BORDER;
    else if (seed_we)   op = OP_SEED;
    else if (start)     op = OP_START;
    else                op = OP_IDLE;
  end

  assign any_grow = |grow_flat;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_b;
    logic row_s;
    assign row_b = (op == OP_BORDER) && (border_row == RW'(r));
    assign row_s = (op == OP_SEED) && (seed_row == RW'(r));
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic nb_n, nb_s, nb_e, nb_w;
      if (r > 0) begin : g_n
        assign nb_n = vis_flat[IDX - COLS];
      end else begin : g_n0
        assign nb_n = 1'b0;
      end
      if (r < ROWS - 1) begin : g_s
        assign nb_s = vis_flat[IDX + COLS];
      end else begin : g_s0
        assign nb_s = 1'b0;
      end
      if (c < COLS - 1) begin : g_e
        assign nb_e = vis_flat[IDX + 1];
      end else begin : g_e0
        assign nb_e = 1'b0;
      end
      if (c > 0) begin : g_w
        assign nb_w = vis_flat[IDX - 1];
      end else begin : g_w0
        assign nb_w = 1'b0;
      end
      ff_cell u_cell (
        .clk       (clk),
        .rst       (rst),
        .clr_all   (op == OP_BORDER),
        .ld_border (row_b),
        .border_in (border_bits[c]),
        .ld_seed   (row_s),
        .seed_in   (seed_bits[c]),
        .step      (busy),
        .nb_n      (nb_n),
        .nb_s      (nb_s),
        .nb_e      (nb_e),
        .nb_w      (nb_w),
        .visited_q (vis_flat[IDX]),
        .grow      (grow_flat[IDX])
      );
    end
  end

  ff_ctrl #(.GW(GW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_go   (op == OP_START),
    .clear_done (op == OP_BORDER || op == OP_SEED),
    .any_grow   (any_grow),
    .busy       (busy),
    .done       (done),
    .gen        (gen_count)
  );

  ff_rdport #(.ROWS(ROWS), .COLS(COLS)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .vis_flat (vis_flat),
    .rd_row   (rd_row),
    .rd_bits  (rd_bits)
  );

  // R9: while a fill runs, the visited count never drops
  assert_no_clear_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> ($countones(vis_flat) >= $countones($past(vis_flat))));
endmodule

// File: tb/tb_flood_fill_grid.sv
`timescale 1ns/1ps
module tb_flood_fill_grid;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int GW   = 16;
  localparam int RW   = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            border_we = 1'b0;
  logic [RW-1:0]   border_row = '0;
  logic [COLS-1:0] border_bits = '0;
  logic            seed_we = 1'b0;
  logic [RW-1:0]   seed_row = '0;
  logic [COLS-1:0] seed_bits = '0;
  logic            start = 1'b0;
  logic [RW-1:0]   rd_row = '0;
  logic [COLS-1:0] rd_bits;
  logic            busy, done;
  logic [GW-1:0]   gen_count;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [COLS-1:0] m_border [ROWS];
  logic [COLS-1:0] m_vis    [ROWS];

  always #2 clk = ~clk;

  flood_fill_grid #(.ROWS(ROWS), .COLS(COLS), .GW(GW)) dut (
    .clk(clk), .rst(rst), .border_we(border_we), .border_row(border_row),
    .border_bits(border_bits), .seed_we(seed_we), .seed_row(seed_row),
    .seed_bits(seed_bits), .start(start), .rd_row(rd_row), .rd_bits(rd_bits),
    .busy(busy), .done(done), .gen_count(gen_count)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_border(input int r, input logic [COLS-1:0] d);
    @(negedge clk);
    border_we = 1'b1; border_row = RW'(r); border_bits = d;
    @(negedge clk);
    border_we = 1'b0;
    m_border[r] = d;
    for (int i = 0; i < ROWS; i++) m_vis[i] = '0;
  endtask

  task automatic load_outline(input logic [COLS-1:0] g [ROWS]);
    for (int r = 0; r < ROWS; r++) write_border(r, g[r]);
  endtask

  task automatic write_seed(input int r, input logic [COLS-1:0] d);
    @(negedge clk);
    seed_we = 1'b1; seed_row = RW'(r); seed_bits = d;
    @(negedge clk);
    seed_we = 1'b0;
    m_vis[r] = m_vis[r] | (d & ~m_border[r]);
  endtask

  task automatic model_fill(output int g);
    logic [COLS-1:0] nxt [ROWS];
    logic changed;
    g = 0;
    forever begin
      changed = 1'b0;
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          logic nb;
          nb = 1'b0;
          if (r > 0)        nb = nb | m_vis[r-1][c];
          if (r < ROWS - 1) nb = nb | m_vis[r+1][c];
          if (c > 0)        nb = nb | m_vis[r][c-1];
          if (c < COLS - 1) nb = nb | m_vis[r][c+1];
          nxt[r][c] = m_vis[r][c] | (nb & ~m_border[r][c]);
          if (nxt[r][c] != m_vis[r][c]) changed = 1'b1;
        end
      end
      if (!changed) break;
      for (int r = 0; r < ROWS; r++) m_vis[r] = nxt[r];
      g++;
    end
  endtask

  task automatic run_fill(input string req, output int wait_cyc);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " R4 busy after start"}, busy, 1);
    wait_cyc = 0;
    while (!done && wait_cyc < 500) begin
      @(negedge clk);
      wait_cyc++;
    end
  endtask

  task automatic check_grid(input string req);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      rd_row = RW'(r);
      @(posedge clk);
      @(negedge clk);
      check({req, " R10 row"}, rd_bits, m_vis[r]);
    end
  endtask

  task automatic finish_and_check(input string req);
    int wc, g;
    run_fill(req, wc);
    model_fill(g);
    check({req, " R7 done"}, done, 1);
    check({req, " R7 idle"}, busy, 0);
    check({req, " R8 gen_count"}, gen_count, g);
    check_grid(req);
  endtask

  function automatic void box(inout logic [COLS-1:0] g [ROWS],
                              input int r0, input int c0, input int r1, input int c1);
    for (int r = r0; r <= r1; r++)
      for (int c = c0; c <= c1; c++)
        if (r == r0 || r == r1 || c == c0 || c == c1) g[r][c] = 1'b1;
  endfunction

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 gen", gen_count, 0);
    for (int i = 0; i < ROWS; i++) begin m_vis[i] = '0; m_border[i] = '0; end
    check_grid("R1");
  endtask

  task automatic t_box();
    logic [COLS-1:0] g [ROWS];
    for (int i = 0; i < ROWS; i++) g[i] = '0;
    box(g, 1, 1, 6, 6);
    load_outline(g);
    write_seed(3, 8'b0000_1000);
    finish_and_check("R5 R11 box");
    check("R8 box depth", gen_count, 4);
  endtask

  task automatic t_open_corner();
    logic [COLS-1:0] g [ROWS];
    for (int i = 0; i < ROWS; i++) g[i] = '0;
    load_outline(g);
    write_seed(0, 8'b0000_0001);
    finish_and_check("R6 open");
    check("R8 corner depth", gen_count, 14);
  endtask

  task automatic t_no_wrap();
    logic [COLS-1:0] g [ROWS];
    for (int i = 0; i < ROWS; i++) g[i] = 8'b0000_0010;
    load_outline(g);
    write_seed(0, 8'b0000_0001);
    finish_and_check("R6 nowrap");
    check("R6 column 7 empty", rd_bits[7], 0);
    check("R6 column depth", gen_count, 7);
  endtask

  task automatic t_two_regions();
    logic [COLS-1:0] g [ROWS];
    for (int i = 0; i < ROWS; i++) g[i] = '0;
    box(g, 0, 0, 4, 3);
    box(g, 0, 4, 7, 7);
    load_outline(g);
    write_seed(2, 8'b0000_0010);
    write_seed(1, 8'b0010_0000);
    finish_and_check("R11 two");
    check("R11 depth max", gen_count, 6);
  endtask

  task automatic t_border_seed();
    logic [COLS-1:0] g [ROWS];
    for (int i = 0; i < ROWS; i++) g[i] = '0;
    box(g, 1, 1, 6, 6);
    load_outline(g);
    write_seed(1, 8'b0000_0100);
    check_grid("R3 border seed");
    finish_and_check("R3 border seed fill");
    check("R3 gen zero", gen_count, 0);
  endtask

  task automatic t_busy_ignored();
    logic [COLS-1:0] g [ROWS];
    int wc, gm;
    for (int i = 0; i < ROWS; i++) g[i] = '0;
    box(g, 1, 1, 6, 6);
    load_outline(g);
    write_seed(2, 8'b0000_0100);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 busy window", busy, 1);
    seed_we = 1'b1; seed_row = 3'd7; seed_bits = 8'b1000_0000;
    @(negedge clk); seed_we = 1'b0;
    border_we = 1'b1; border_row = 3'd3; border_bits = 8'b1111_1111;
    @(negedge clk); border_we = 1'b0;
    wc = 0;
    while (!done && wc < 500) begin @(negedge clk); wc++; end
    model_fill(gm);
    check("R9 done", done, 1);
    check("R9 gen", gen_count, gm);
    check_grid("R9 writes ignored");
  endtask

  task automatic t_reload_clears();
    check("R7 done held", done, 1);
    write_border(0, '0);
    check("R2 done cleared", done, 0);
    check_grid("R2 visited cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_box();
    t_reload_clears();
    t_open_corner();
    t_no_wrap();
    t_two_regions();
    t_border_seed();
    t_busy_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule